// File: doc/BRIEF.md
# Two-Cycle System Bus Master

This block runs single read and write transfers on a shared parallel system bus for a small processor core. The core hands over one request at a time: an address, write data, a direction flag and a flag that says whether the target is memory or an I/O port. The block turns each request into a fixed two-clock bus transfer.

In the first clock the address is placed on the bus. In the second clock the read or write strobe is active. For a read, the value on the incoming data bus is captured at the end of the strobe clock. A one-cycle completion pulse then tells the core that the transfer is over. The captured value stays visible until a later read replaces it.

The address bus only ever leaves the block. Writes drive the outgoing data bus with its output enable raised for both clocks of the transfer. Reads leave the data bus released so that the target can drive it. A separate select line marks each transfer as an I/O or memory access, so a port and a memory word may share one address. A parameter selects whether both strobes are active high or active low.

Top module: `sysbus_master`

## Requirements
- R1: While reset is applied and on the first cycle after it, the block is idle. Busy and done are 0, the address bus and captured read data are all zeros, the output enable and I/O select are 0, and both strobes sit at their inactive level.
- R2: In the cycle after an idle block samples a read request, the address bus carries the requested address. The read strobe is still inactive and the output enable is 0.
- R3: In the following cycle the read strobe is active and the address bus still carries the same address.
- R4: The read data output takes the incoming data bus value sampled at the end of the read strobe cycle. It keeps that value through any later write until the next read completes.
- R5: In the cycle after the strobe cycle, done is 1 for exactly one cycle. The address bus returns to zero, both strobes are inactive and busy is 0.
- R6: For a write, the address, the write data and the output enable (1) are driven in both transfer cycles. The write strobe is inactive in the first cycle and active in the second. The read strobe stays inactive throughout.
- R7: The I/O select output equals the request's I/O flag during both transfer cycles and is 0 when idle.
- R8: A request presented while the block is busy is ignored. The transfer in progress keeps its address and ends normally, and no new transfer follows unless a request is present while idle.
- R9: With the polarity parameter set to active low, both strobe outputs are the bitwise inverse of the active-high version under the same stimulus.
- R10: The read and write strobes are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Core presents a request this cycle |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Data for a write |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O port, 0 = memory |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Last captured read data |
| bus_addr | output | ADDR_W | Address bus, driven only by this block |
| bus_dout | output | DATA_W | Outgoing data bus value |
| bus_dout_en | output | 1 | Output enable for the outgoing data bus |
| bus_din | input | DATA_W | Incoming data bus value |
| bus_rd | output | 1 | Read strobe, polarity set by parameter |
| bus_wr | output | 1 | Write strobe, polarity set by parameter |
| bus_io | output | 1 | 1 = I/O access, 0 = memory access |

## Verification
The hardest case to reach from the ports is a request that arrives while a transfer is already under way. The bench reaches it by holding the request valid with a different address and opposite direction through both transfer cycles. It then lowers the request just before the strobe cycle ends, and checks that the original address was kept and that the block goes idle instead of starting the second transfer. Read-data retention is covered by following a read with writes that drive a conflicting value on the incoming data bus. A second instance with active-low strobes runs in parallel and is compared phase by phase.

// File: rtl/sysbus_pkg.sv
// Package: types shared by the bus master and its sub-blocks.
package sysbus_pkg;
    // Transfer phase: idle, address-only setup cycle, strobe cycle.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_STRB  = 2'd2
    } phase_t;
endpackage

// File: rtl/sb_sequencer.sv
// Module: sb_sequencer
// Holds one accepted request and steps it through setup and strobe
// cycles. Assumes requests are only taken while idle; later requests
// are ignored until the transfer ends.
module sb_sequencer
    import sysbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    output phase_t            phase,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              oe_o,
    output logic              io_o,
    output logic              rd_act,
    output logic              wr_act,
    output logic              cap_en,
    output logic              done_o
);
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic              lat_write;
    logic              lat_io;
    logic              accept;

    assign accept = (phase == PH_IDLE) && req_valid;

    // Phase register: idle -> setup -> strobe -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE:  phase <= accept ? PH_SETUP : PH_IDLE;
                PH_SETUP: phase <= PH_STRB;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // Request latch: captured only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_write <= 1'b0;
            lat_io    <= 1'b0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_write <= req_write;
            lat_io    <= req_io;
        end
    end

    // Completion pulse: follows the strobe cycle by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= (phase == PH_STRB);
    end

    // Bus-side outputs: zero when idle, latched request otherwise.
    always_comb begin
        addr_o  = (phase != PH_IDLE) ? lat_addr : '0;
        io_o    = (phase != PH_IDLE) && lat_io;
        oe_o    = (phase != PH_IDLE) && lat_write;
        wdata_o = oe_o ? lat_wdata : '0;
        rd_act  = (phase == PH_STRB) && !lat_write;
        wr_act  = (phase == PH_STRB) && lat_write;
        cap_en  = rd_act;
    end

    // R8 / R3: address held from setup into strobe cycle.
    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETUP) |=> $stable(addr_o));
    // R5: done is a single-cycle pulse.
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7: select is low when idle.
    assert_io_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !io_o);
endmodule

// File: rtl/sb_strobe_drv.sv
// Module: sb_strobe_drv
// Maps internal strobe activity onto pin levels. ACTIVE_HIGH picks
// the polarity for both strobes at elaboration.
module sb_strobe_drv #(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_act,
    input  logic wr_act,
    output logic rd_pin,
    output logic wr_pin
);
    generate
        if (ACTIVE_HIGH) begin : g_high
            // Pass activity straight to the pins.
            always_comb begin
                rd_pin = rd_act;
                wr_pin = wr_act;
            end
        end else begin : g_low
            // Invert activity for active-low pins.
            always_comb begin
                rd_pin = ~rd_act;
                wr_pin = ~wr_act;
            end
        end
    endgenerate

    // R10: never both strobes at once.
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_act && wr_act));
endmodule

// File: rtl/sb_read_capture.sv
// Module: sb_read_capture
// Register for read data. Samples the incoming bus at the end of a
// read strobe cycle and holds it otherwise.
module sb_read_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata
);
    // Capture register: loads only on cap_en.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (cap_en) rdata <= din;
    end

    // R4: held when no capture is requested.
    assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(rdata));
endmodule

// File: rtl/sysbus_master.sv
// Module: sysbus_master
// Two-clock single-transfer system bus master with isolated I/O select
// and parameter-chosen strobe polarity. Assumes zero-wait-state targets.
module sysbus_master
    import sysbus_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter bit STROBE_HIGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    input  logic [DATA_W-1:0] bus_din,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_io
);
    phase_t phase;
    logic   rd_act;
    logic   wr_act;
    logic   cap_en;

    sb_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_write(req_write),
        .req_io   (req_io),
        .phase    (phase),
        .addr_o   (bus_addr),
        .wdata_o  (bus_dout),
        .oe_o     (bus_dout_en),
        .io_o     (bus_io),
        .rd_act   (rd_act),
        .wr_act   (wr_act),
        .cap_en   (cap_en),
        .done_o   (done)
    );

    sb_strobe_drv #(.ACTIVE_HIGH(STROBE_HIGH)) u_strb (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_act(rd_act),
        .wr_act(wr_act),
        .rd_pin(bus_rd),
        .wr_pin(bus_wr)
    );

    sb_read_capture #(.DATA_W(DATA_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_en(cap_en),
        .din   (bus_din),
        .rdata (rdata)
    );

    // Busy flag seen by the core.
    assign busy = (phase != PH_IDLE);

    // R6: output enable only inside a transfer.
    assert_oe_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_en |-> busy);
    // R2: a strobe is never active on the first cycle of a transfer.
    assert_strobe_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !(rd_act || wr_act));
    // R5: address released once done shows.
    assert_addr_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_addr == '0 || busy));
endmodule

// File: tb/tb_sysbus_master.sv
module tb_sysbus_master;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_write = 1'b0;
    logic          req_io = 1'b0;
    logic [DW-1:0] bus_din = '0;
    logic          busy, done, bus_dout_en, bus_rd, bus_wr, bus_io;
    logic [DW-1:0] rdata, bus_dout;
    logic [AW-1:0] bus_addr;
    logic          lo_busy, lo_done, lo_oe, lo_rd, lo_wr, lo_io;
    logic [DW-1:0] lo_rdata, lo_dout;
    logic [AW-1:0] lo_addr;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] exp_rdata = '0;

    always #10 clk = ~clk;

    sysbus_master #(.ADDR_W(AW), .DATA_W(DW), .STROBE_HIGH(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
        .busy(busy), .done(done), .rdata(rdata), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_io(bus_io));

    sysbus_master #(.ADDR_W(AW), .DATA_W(DW), .STROBE_HIGH(1'b0)) dut_lo (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
        .busy(lo_busy), .done(lo_done), .rdata(lo_rdata), .bus_addr(lo_addr),
        .bus_dout(lo_dout), .bus_dout_en(lo_oe), .bus_din(bus_din),
        .bus_rd(lo_rd), .bus_wr(lo_wr), .bus_io(lo_io));

    // Vector: {write, io, addr[15:0], wdata[7:0], din[7:0]}
    localparam int VW = 2 + AW + 2*DW;
    localparam int NV = 6;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 1'b0, 16'h1234, 8'h00, 8'hA5},
        {1'b1, 1'b0, 16'h1234, 8'h3C, 8'hFF},
        {1'b0, 1'b1, 16'h1234, 8'h00, 8'h5A},
        {1'b1, 1'b1, 16'h00FF, 8'hC3, 8'h11},
        {1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h00},
        {1'b0, 1'b1, 16'h8001, 8'h00, 8'hFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_pol();
        chk("R9 rd polarity", {31'd0, lo_rd}, {31'd0, ~bus_rd});
        chk("R9 wr polarity", {31'd0, lo_wr}, {31'd0, ~bus_wr});
    endtask

    task automatic chk_idle(input string req);
        chk({req, " busy"}, {31'd0, busy}, 32'd0);
        chk({req, " addr"}, {16'd0, bus_addr}, 32'd0);
        chk({req, " rd"}, {31'd0, bus_rd}, 32'd0);
        chk({req, " wr"}, {31'd0, bus_wr}, 32'd0);
        chk({req, " oe"}, {31'd0, bus_dout_en}, 32'd0);
        chk({req, " io"}, {31'd0, bus_io}, 32'd0);
        chk_pol();
    endtask

    // One full transfer; if hold_busy, keep a conflicting request valid
    // through both transfer cycles (R8).
    task automatic xfer(input logic wr, input logic io, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic [DW-1:0] din,
                        input bit hold_busy);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_io = io; req_addr = a; req_wdata = wd;
        bus_din = ~din;
        @(negedge clk); // setup cycle
        if (hold_busy) begin
            req_addr = ~a; req_write = ~wr; req_io = ~io;
        end else begin
            req_valid = 1'b0;
        end
        chk("R2 setup addr", {16'd0, bus_addr}, {16'd0, a});
        chk("R2 setup rd inactive", {31'd0, bus_rd}, 32'd0);
        chk("R6 setup wr inactive", {31'd0, bus_wr}, 32'd0);
        chk("R6 setup oe", {31'd0, bus_dout_en}, {31'd0, wr});
        if (wr) chk("R6 setup data", {24'd0, bus_dout}, {24'd0, wd});
        chk("R7 setup io", {31'd0, bus_io}, {31'd0, io});
        chk_pol();
        @(negedge clk); // strobe cycle
        req_valid = 1'b0;
        bus_din = din;
        chk("R3 strobe addr", {16'd0, bus_addr}, {16'd0, a});
        chk("R3 rd strobe", {31'd0, bus_rd}, {31'd0, ~wr});
        chk("R6 wr strobe", {31'd0, bus_wr}, {31'd0, wr});
        chk("R10 exclusive", {31'd0, bus_rd & bus_wr}, 32'd0);
        chk("R6 strobe oe", {31'd0, bus_dout_en}, {31'd0, wr});
        if (wr) chk("R6 strobe data", {24'd0, bus_dout}, {24'd0, wd});
        chk("R7 strobe io", {31'd0, bus_io}, {31'd0, io});
        chk("R5 no early done", {31'd0, done}, 32'd0);
        chk_pol();
        @(negedge clk); // done cycle
        if (!wr) exp_rdata = din;
        bus_din = ~din;
        chk("R5 done", {31'd0, done}, 32'd1);
        chk("R4 rdata", {24'd0, rdata}, {24'd0, exp_rdata});
        chk_idle("R5 after");
        @(negedge clk);
        chk("R5 done single", {31'd0, done}, 32'd0);
        chk("R8 no new transfer", {31'd0, busy}, 32'd0);
        chk("R4 rdata held", {24'd0, rdata}, {24'd0, exp_rdata});
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk_idle("R1 in reset");
        chk("R1 rdata", {24'd0, rdata}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after reset");
        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i][VW-1], VEC[i][VW-2], VEC[i][2*DW +: AW],
                 VEC[i][DW +: DW], VEC[i][0 +: DW], 1'b0);
        end
        // R8: conflicting request held valid while busy.
        xfer(1'b0, 1'b1, 16'h0F0F, 8'h00, 8'h77, 1'b1);
        xfer(1'b1, 1'b0, 16'hA0A0, 8'h99, 8'h01, 1'b1);
        // R4: back-to-back writes keep last read data.
        xfer(1'b1, 1'b1, 16'h0002, 8'hEE, 8'h55, 1'b0);
        chk("R4 held over writes", {24'd0, rdata}, 32'h01 & 32'h0 | {24'd0, exp_rdata});
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule